// File: doc/BRIEF.md
# Read QoS Traffic Class Mapper

This block sits at a read port of a memory controller. It sorts each incoming read request into a traffic class (low, variable or high priority) by its 4-bit QoS value. Two programmable thresholds split the QoS range into three consecutive regions, and each region carries its own class code. When the controller is built without variable-priority support, a region that is programmed as variable priority gives low priority. When the controller is built with two address queues, the block also says which queue takes the request: the lowest two regions go to the blue queue and the top region goes to the red queue.

The configuration is quasi-dynamic. Software writes a 32-bit word into a shadow copy. That copy moves into the active configuration only in a cycle where the update enable is high and no request is being classified. Every write is checked against the rules for the build's queue mode, and an error flag is raised for an illegal word. An illegal word is never made active. The classification is registered and appears one cycle after the request.

Top module: `rd_qos_mapper`

## Requirements
- R1: With active thresholds lo and hi, a QoS value q selects region 0 when q <= lo, region 1 when lo < q <= hi, and region 2 when q > hi. The region index is given on region_o.
- R2: cls_o is the 2-bit class code of the selected region, where 0 = low, 1 = variable and 2 = high priority. A valid output never carries code 3.
- R3: When VPR_EN = 0, a region programmed with code 1 produces class 0. When VPR_EN = 1, code 1 is passed through unchanged.
- R4: When DUAL_Q = 1, red_q_o is 1 for region 2 and 0 for regions 0 and 1. When DUAL_Q = 0, red_q_o is always 0.
- R5: cls_vld_o is high in the cycle after each cycle with req_vld_i high and low otherwise. The class, region and queue outputs are registered with it.
- R6: A configuration write changes only the shadow copy. The shadow copy moves to the active configuration at a clock edge only when cfg_upd_en_i is high, req_vld_i is low and the shadow copy is legal.
- R7: cfg_err_o is high while the shadow copy breaks the threshold rules: hi <= lo, hi > 14, or lo above its mode limit (13 with two queues, 14 with one queue).
- R8: cfg_err_o is also high when any region code is 3. With two queues it is also high when region 0 or region 1 holds code 2, or when region 2 holds code 0.
- R9: While cfg_err_o is high, an update request leaves the active configuration and the classification unchanged.
- R10: Reset sets both copies to lo = 0, hi = 14, region 0 = low, region 1 = low, region 2 = high, clears cls_vld_o, cls_o, region_o and red_q_o, and leaves cfg_err_o low.
- R11: The configuration word holds lo in bits 3:0, hi in bits 11:8 and the region 0, 1 and 2 codes in bits 17:16, 21:20 and 25:24. All other bits are ignored, and the reset word is 0x02000E00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_vld_i | input | 1 | Read request present this cycle |
| req_qos_i | input | QOS_W | QoS value of the request |
| cfg_we_i | input | 1 | Write the configuration word into the shadow copy |
| cfg_wdata_i | input | CFG_W | Configuration word |
| cfg_upd_en_i | input | 1 | Allow the shadow-to-active copy |
| cfg_err_o | output | 1 | Shadow copy is illegal for this build |
| cls_vld_o | output | 1 | Classification valid |
| cls_o | output | 2 | Traffic class code |
| region_o | output | 2 | Selected region index |
| red_q_o | output | 1 | Request targets the red queue |

## Verification
On every cycle, the assertions check the following. cls_vld_o follows req_vld_i with one cycle of delay. A valid output never carries code 3. Variable priority never appears when it is disabled. The queue flag agrees with region 2 in dual mode and stays low in single mode. The active copy holds still while the error flag is set, and also while an update is blocked by a request or by a low enable. Only the bench scenarios can show that the thresholds are inclusive at both edges and that the class codes come from the right register fields. They also show that unused word bits have no effect, that the reset word classifies as specified, and that one illegal word is rejected in dual mode but accepted in single mode.

// File: rtl/rqm_pkg.sv
package rqm_pkg;
  localparam int QOS_W      = 4;
  localparam int CLS_W      = 2;
  localparam int N_REG      = 3;
  localparam int REG_W      = $clog2(N_REG);
  localparam int CFG_W      = 32;
  localparam int LO_LSB     = 0;
  localparam int HI_LSB     = 8;
  localparam int REG_LSB    = 16;
  localparam int REG_STRIDE = 4;
  localparam int QOS_MAX    = (1 << QOS_W) - 1;

  localparam logic [CLS_W-1:0] CLS_LOW  = 2'd0;
  localparam logic [CLS_W-1:0] CLS_VAR  = 2'd1;
  localparam logic [CLS_W-1:0] CLS_HIGH = 2'd2;
  localparam logic [CLS_W-1:0] CLS_BAD  = 2'd3;

  typedef struct packed {
    logic [N_REG-1:0][CLS_W-1:0] rcls;
    logic [QOS_W-1:0]            hi;
    logic [QOS_W-1:0]            lo;
  } map_cfg_t;

  localparam map_cfg_t CFG_RST = '{
    rcls: {CLS_HIGH, CLS_LOW, CLS_LOW},
    hi:   QOS_W'(QOS_MAX - 1),
    lo:   '0
  };
endpackage

// File: rtl/rqm_cfg_regs.sv
module rqm_cfg_regs
  import rqm_pkg::*;
#(
  parameter bit DUAL_Q = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             upd_en_i,
  input  logic             busy_i,
  output map_cfg_t         active_o,
  output logic             err_o
);
  localparam logic [QOS_W-1:0] HI_MAX = QOS_W'(QOS_MAX - 1);
  localparam logic [QOS_W-1:0] LO_MAX = DUAL_Q ? QOS_W'(QOS_MAX - 2) : QOS_W'(QOS_MAX - 1);

  map_cfg_t wr_cfg, shadow_q, active_q;
  logic     bad;
  logic     unused_wbits;

  assign wr_cfg.lo = wdata_i[LO_LSB +: QOS_W];
  assign wr_cfg.hi = wdata_i[HI_LSB +: QOS_W];
  for (genvar k = 0; k < N_REG; k++) begin : g_unpack
    assign wr_cfg.rcls[k] = wdata_i[REG_LSB + REG_STRIDE*k +: CLS_W];
  end
  assign unused_wbits = ^wdata_i;

  always_comb begin
    bad = (shadow_q.hi <= shadow_q.lo) || (shadow_q.hi > HI_MAX) || (shadow_q.lo > LO_MAX);
    for (int k = 0; k < N_REG; k++) begin
      if (shadow_q.rcls[k] == CLS_BAD) bad = 1'b1;
      if (DUAL_Q) begin
        // lower regions feed blue queue: no HPR; top region feeds red: no LPR
        if (k < N_REG-1 && shadow_q.rcls[k] == CLS_HIGH) bad = 1'b1;
        if (k == N_REG-1 && shadow_q.rcls[k] == CLS_LOW) bad = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= CFG_RST;
      active_q <= CFG_RST;
    end else begin
      if (we_i) shadow_q <= wr_cfg;
      if (upd_en_i && !busy_i && !bad) active_q <= shadow_q;
    end
  end

  assign active_o = active_q;
  assign err_o    = bad;

  // R9
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> $stable(active_q));
  // R6
  blocked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i || !upd_en_i) |=> $stable(active_q));
  // R7
  active_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q.hi > active_q.lo);
endmodule

// File: rtl/rqm_region_dec.sv
module rqm_region_dec
  import rqm_pkg::*;
(
  input  logic [QOS_W-1:0] qos_i,
  input  logic [QOS_W-1:0] lo_i,
  input  logic [QOS_W-1:0] hi_i,
  output logic [REG_W-1:0] region_o
);
  always_comb begin
    if (qos_i <= lo_i)      region_o = REG_W'(0);
    else if (qos_i <= hi_i) region_o = REG_W'(1);
    else                    region_o = REG_W'(2);
  end
endmodule

// File: rtl/rqm_class_sel.sv
module rqm_class_sel
  import rqm_pkg::*;
#(
  parameter bit DUAL_Q = 1'b0,
  parameter bit VPR_EN = 1'b1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_vld_i,
  input  logic [REG_W-1:0]            region_i,
  input  logic [N_REG-1:0][CLS_W-1:0] rcls_i,
  output logic                        vld_o,
  output logic [CLS_W-1:0]            cls_o,
  output logic [REG_W-1:0]            region_o,
  output logic                        red_o
);
  logic [CLS_W-1:0] code, cls_n;
  logic             red_n;
  logic             vld_q, red_q;
  logic [CLS_W-1:0] cls_q;
  logic [REG_W-1:0] reg_q;

  assign code = rcls_i[region_i];

  if (VPR_EN) begin : g_vpr
    assign cls_n = code;
  end else begin : g_alias
    assign cls_n = (code == CLS_VAR) ? CLS_LOW : code;
  end

  if (DUAL_Q) begin : g_dual
    assign red_n = (region_i == REG_W'(N_REG-1));
  end else begin : g_single
    assign red_n = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      cls_q <= '0;
      reg_q <= '0;
      red_q <= 1'b0;
    end else begin
      vld_q <= req_vld_i;
      if (req_vld_i) begin
        cls_q <= cls_n;
        reg_q <= region_i;
        red_q <= red_n;
      end
    end
  end

  assign vld_o    = vld_q;
  assign cls_o    = cls_q;
  assign region_o = reg_q;
  assign red_o    = red_q;

  // R5
  vld_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_vld_i |=> vld_q);
  // R5
  vld_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_vld_i |=> !vld_q);
  // R2
  cls_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> cls_q != CLS_BAD);
  // R1
  region_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> reg_q < REG_W'(N_REG));

  if (!VPR_EN) begin : g_alias_chk
    // R3
    no_var_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_q |-> cls_q != CLS_VAR);
  end

  if (DUAL_Q) begin : g_dual_chk
    // R4
    red_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_q |-> (red_q == (reg_q == REG_W'(N_REG-1))));
  end else begin : g_single_chk
    // R4
    single_blue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !red_q);
  end
endmodule

// File: rtl/rd_qos_mapper.sv
module rd_qos_mapper
  import rqm_pkg::*;
#(
  parameter bit DUAL_Q = 1'b0,
  parameter bit VPR_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_vld_i,
  input  logic [QOS_W-1:0] req_qos_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             cfg_upd_en_i,
  output logic             cfg_err_o,
  output logic             cls_vld_o,
  output logic [CLS_W-1:0] cls_o,
  output logic [REG_W-1:0] region_o,
  output logic             red_q_o
);
  map_cfg_t         act;
  logic [REG_W-1:0] region;

  rqm_cfg_regs #(.DUAL_Q(DUAL_Q)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .wdata_i  (cfg_wdata_i),
    .upd_en_i (cfg_upd_en_i),
    .busy_i   (req_vld_i),
    .active_o (act),
    .err_o    (cfg_err_o)
  );

  rqm_region_dec u_dec (
    .qos_i    (req_qos_i),
    .lo_i     (act.lo),
    .hi_i     (act.hi),
    .region_o (region)
  );

  rqm_class_sel #(.DUAL_Q(DUAL_Q), .VPR_EN(VPR_EN)) u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_vld_i (req_vld_i),
    .region_i  (region),
    .rcls_i    (act.rcls),
    .vld_o     (cls_vld_o),
    .cls_o     (cls_o),
    .region_o  (region_o),
    .red_o     (red_q_o)
  );
endmodule

// File: tb/sim_rd_qos_mapper.sv
module sim_rd_qos_mapper;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;
  // {cfg word, qos, expected region, expected class} for single queue, VPR on
  localparam logic [39:0] VEC [0:NV-1] = '{
    {32'h02000E00, 4'd0,  2'd0, 2'd0},
    {32'h02000E00, 4'd1,  2'd1, 2'd0},
    {32'h02000E00, 4'd14, 2'd1, 2'd0},
    {32'h02000E00, 4'd15, 2'd2, 2'd2},
    {32'h00120A05, 4'd5,  2'd0, 2'd2},
    {32'h00120A05, 4'd6,  2'd1, 2'd1},
    {32'h00120A05, 4'd10, 2'd1, 2'd1},
    {32'h00120A05, 4'd11, 2'd2, 2'd0},
    {32'h01210E0D, 4'd13, 2'd0, 2'd1},
    {32'h01210E0D, 4'd14, 2'd1, 2'd2},
    {32'h01210E0D, 4'd15, 2'd2, 2'd1},
    {32'hFCEDF3F1, 4'd2,  2'd1, 2'd2},
    {32'hFCEDF3F1, 4'd4,  2'd2, 2'd0},
    {32'hFCEDF3F1, 4'd1,  2'd0, 2'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_vld = 1'b0, we = 1'b0, upd = 1'b0;
  logic [3:0] qos = '0;
  logic [31:0] wdata = '0;
  logic err0, vld0, red0, err1, vld1, red1;
  logic [1:0] cls0, reg0, cls1, reg1;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rd_qos_mapper u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_vld_i(req_vld), .req_qos_i(qos),
    .cfg_we_i(we), .cfg_wdata_i(wdata), .cfg_upd_en_i(upd),
    .cfg_err_o(err0), .cls_vld_o(vld0), .cls_o(cls0), .region_o(reg0), .red_q_o(red0)
  );

  rd_qos_mapper #(.DUAL_Q(1'b1), .VPR_EN(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_vld_i(req_vld), .req_qos_i(qos),
    .cfg_we_i(we), .cfg_wdata_i(wdata), .cfg_upd_en_i(upd),
    .cfg_err_o(err1), .cls_vld_o(vld1), .cls_o(cls1), .region_o(reg1), .red_q_o(red1)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [31:0] w);
    @(negedge clk); we = 1'b1; wdata = w;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic cfg_update();
    @(negedge clk); upd = 1'b1;
    @(negedge clk); upd = 1'b0;
  endtask

  // drives one request; returns at the negedge where outputs are registered
  task automatic send(input logic [3:0] q, input logic with_upd);
    @(negedge clk); req_vld = 1'b1; qos = q; upd = with_upd;
    @(negedge clk); req_vld = 1'b0; upd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(vld0, 0, "R10 vld");  chk(cls0, 0, "R10 cls");
    chk(reg0, 0, "R10 region"); chk(red0, 0, "R10 red");
    chk(err0, 0, "R10 err0"); chk(err1, 0, "R10 err1");
    send(4'd15, 1'b0);
    chk(reg0, 2, "R10 default region"); chk(cls0, 2, "R10 default cls");
    chk(red1, 1, "R4 dual red on default top region");
    @(negedge clk);
    chk(vld0, 0, "R5 vld drops when idle");

    // R1 R2 R11 table walk
    for (int i = 0; i < NV; i++) begin
      cfg_write(VEC[i][39:8]);
      chk(err0, 0, "R11 legal word no err");
      cfg_update();
      send(VEC[i][7:4], 1'b0);
      chk(vld0, 1, "R5 vld");
      chk(reg0, int'(VEC[i][3:2]), "R1 region");
      chk(cls0, int'(VEC[i][1:0]), "R2 class");
      chk(red0, 0, "R4 single queue blue");
    end
    // active now lo=1 hi=3 r0=1 r1=2 r2=0

    // R6 no copy without update enable
    cfg_write(32'h00120A05);
    send(4'd2, 1'b0);
    chk(reg0, 1, "R6 no update without enable");
    // R6 copy blocked by concurrent request
    send(4'd2, 1'b1);
    chk(reg0, 1, "R6 update blocked by request");
    send(4'd2, 1'b0);
    chk(reg0, 1, "R6 still old after blocked update");
    cfg_update();
    send(4'd2, 1'b0);
    chk(reg0, 0, "R6 update applied");

    // R7 hi == lo
    cfg_write(32'h00000505);
    chk(err0, 1, "R7 hi equals lo");
    cfg_update();
    send(4'd6, 1'b0);
    chk(reg0, 1, "R9 region unchanged under error");
    chk(cls0, 1, "R9 class unchanged under error");
    // R7 hi above 14
    cfg_write(32'h00000F03);
    chk(err0, 1, "R7 hi out of range");
    // R8 code 3
    cfg_write(32'h00300A05);
    chk(err0, 1, "R8 code 3 region1");
    // R8 dual-only illegal
    cfg_write(32'h02200A05);
    chk(err0, 0, "R8 single accepts HPR in region1");
    chk(err1, 1, "R8 dual rejects HPR in region1");
    cfg_write(32'h00000A05);
    chk(err1, 1, "R8 dual rejects LPR in region2");
    chk(err0, 0, "R8 single accepts LPR in region2");
    // R7 lo limit in dual mode
    cfg_write(32'h01010E0D);
    chk(err1, 0, "R7 dual lo 13 accepted");

    // R3 R4 alias and routing: lo=3 hi=8 r0=VPR r1=LPR r2=VPR
    cfg_write(32'h01010803);
    chk(err0, 0, "R3 word legal u0"); chk(err1, 0, "R3 word legal u1");
    cfg_update();
    send(4'd2, 1'b0);
    chk(cls0, 1, "R3 VPR kept when enabled");
    chk(cls1, 0, "R3 VPR aliased to LPR");
    chk(red1, 0, "R4 region0 blue");
    send(4'd5, 1'b0);
    chk(reg1, 1, "R1 dual region1"); chk(red1, 0, "R4 region1 blue");
    send(4'd9, 1'b0);
    chk(reg1, 2, "R1 dual region2"); chk(red1, 1, "R4 region2 red");
    chk(cls1, 0, "R3 aliased on red queue");
    chk(red0, 0, "R4 single never red");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule